// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block gathers the interrupt causes of a FIFO-capable UART and presents them to a processor as one identification byte and one request line. The serial shifters, FIFOs and baud logic live elsewhere. Their condition arrives here as levels (receive data available, receive timeout, line error) and as single-cycle strobes (transmit holding register became empty, holding register written, identification byte read, modem status read). The block also watches the four modem input lines and keeps a sticky change flag for each one.

A registered state machine chooses the cause to report. It has five states: `ST_IDLE` (nothing pending), `ST_LINE`, `ST_RXD`, `ST_THRE` and `ST_MODEM`. On every clock it moves to the state of the highest-priority enabled cause that is active. All transitions are direct: any state can go to any other state, and `ST_IDLE` is taken when no enabled cause is active. The order is: line error first, then receive data or timeout, then transmit holding empty, then modem change. A master enable input gates the request pin. The 4-bit enable register filters each cause individually.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to the enable register stores data bits 3:0: bit0 receive, bit1 transmit-empty, bit2 line error, bit3 modem change. Read-back bits 7:4 are always zero. Reset clears the register.
- R2: Identification bits 2:1 carry the reported cause: 11 for line error, 10 for receive data or timeout, 01 for transmit holding empty, 00 for modem change. When several causes are active and enabled, the first one in that order is reported.
- R3: Identification bit 0 is 0 while a cause is pending and 1 when none is pending. After reset the byte reads 0x01.
- R4: Identification bit 3 is 1 only when the receive timeout input is set in FIFO mode and the reported code is 10. A timeout enters the receive cause only when FIFO mode is on.
- R5: Identification bits 7:6 read 11 when the FIFO-enable input is high and 00 when it is low. Bits 5:4 read 0.
- R6: The request output is high only while the master enable input is high and a cause is pending. With master enable low it stays low even though the identification byte shows a pending cause.
- R7: The modem status byte is {dcd, ri, dsr, cts, dDCD, dRI, dDSR, dCTS} from bit 7 down. The upper nibble shows the live line levels. A modem status read clears all four sticky flags. A modem-change cause exists only while enable bit3 is set and a flag is set.
- R8: The RI flag is set only when ri falls. The CTS, DSR and DCD flags are set on either edge.
- R9: The transmit-empty cause is latched by its set strobe. It is cleared by a holding-register write strobe, or by an identification read taken while the byte reports code 01.
- R10: Level inputs and enable changes reach the identification byte one clock after the edge that samples them. Strobe-driven and line-change-driven causes reach it two clocks after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read-back |
| master_en | input | 1 | Master request enable |
| fifo_mode | input | 1 | FIFOs enabled |
| rx_avail | input | 1 | Receive data available (level) |
| rx_timeout | input | 1 | Receive FIFO timeout (level) |
| line_err | input | 1 | Line error or break pending (level) |
| thr_empty | input | 1 | Holding register became empty (strobe) |
| thr_write | input | 1 | Holding register written (strobe) |
| iir_rd | input | 1 | Identification byte read (strobe) |
| msr_rd | input | 1 | Modem status read (strobe) |
| cts | input | 1 | Clear-to-send line |
| dsr | input | 1 | Data-set-ready line |
| ri | input | 1 | Ring line |
| dcd | input | 1 | Carrier-detect line |
| iir_data | output | 8 | Identification byte |
| msr_data | output | 8 | Modem status byte |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed due cycle. A level or enable-register change shows in the identification byte one clock later. A strobe, or a modem line edge, takes two clocks: one to latch the condition and one to move the state machine. A modem line edge shows in the status byte after one clock. The driver applies stimulus just after a rising edge and queues each expected value tagged with its due cycle. The monitor compares on the falling edge of exactly that cycle and counts a failure if an expected item is left past its cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE,
        ST_RXD,
        ST_THRE,
        ST_MODEM
    } cause_e;

    localparam logic [1:0] CODE_LINE  = 2'b11;
    localparam logic [1:0] CODE_RXD   = 2'b10;
    localparam logic [1:0] CODE_THRE  = 2'b01;
    localparam logic [1:0] CODE_MODEM = 2'b00;
endpackage

// File: rtl/modem_delta.sv
module modem_delta #(
    parameter int NLINES = 4,
    parameter logic [NLINES-1:0] TRAIL_ONLY = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines,
    input  logic              rd_clr,
    output logic [NLINES-1:0] delta
);
    logic [NLINES-1:0] prev_q;
    logic              primed_q;
    logic [NLINES-1:0] hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lines;
            primed_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (TRAIL_ONLY[i]) begin : g_fall
            assign hit[i] = primed_q & prev_q[i] & ~lines[i];
        end else begin : g_any
            assign hit[i] = primed_q & (prev_q[i] ^ lines[i]);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)       delta[i] <= 1'b0;
            else if (hit[i])  delta[i] <= 1'b1;
            else if (rd_clr)  delta[i] <= 1'b0;
        end
    end

    // R7: a read with no new edge leaves every flag clear
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && hit == '0) |=> (delta == '0));

    // R8: ring rising edge never raises its flag
    assert_ring_trailing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !prev_q[2] && lines[2] && !delta[2]) |=> !delta[2]);
endmodule

// File: rtl/thre_latch.sv
module thre_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_wr,
    input  logic clr_rd,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)               pend <= 1'b0;
        else if (set_ev)          pend <= 1'b1;
        else if (clr_wr || clr_rd) pend <= 1'b0;
    end

    // R9: a clear without a set empties the latch
    assert_thre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && (clr_wr || clr_rd)) |=> !pend);
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import uirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_c,
    input  logic       rx_c,
    input  logic       to_c,
    input  logic       thre_c,
    input  logic       mdm_c,
    input  logic       fifo_mode,
    output cause_e     state,
    output logic [7:0] iir,
    output logic       pending
);
    cause_e next;
    logic   to_q;

    always_comb begin
        if (line_c)      next = ST_LINE;
        else if (rx_c)   next = ST_RXD;
        else if (thre_c) next = ST_THRE;
        else if (mdm_c)  next = ST_MODEM;
        else             next = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            to_q  <= 1'b0;
        end else begin
            state <= next;
            to_q  <= (next == ST_RXD) && to_c;
        end
    end

    always_comb begin
        iir       = 8'h00;
        iir[7:6]  = fifo_mode ? 2'b11 : 2'b00;
        pending   = 1'b1;
        unique case (state)
            ST_IDLE: begin
                iir[0]  = 1'b1;
                pending = 1'b0;
            end
            ST_LINE:  iir[2:1] = CODE_LINE;
            ST_RXD: begin
                iir[2:1] = CODE_RXD;
                iir[3]   = to_q;
            end
            ST_THRE:  iir[2:1] = CODE_THRE;
            ST_MODEM: iir[2:1] = CODE_MODEM;
            default: begin
                iir[0]  = 1'b1;
                pending = 1'b0;
            end
        endcase
    end

    // R2: a line error always wins the next state
    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_c |=> (state == ST_LINE));

    // R2: transmit-empty never shadows receive data
    assert_rx_over_thre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_c && rx_c) |=> (state == ST_RXD));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int IER_BITS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [7:0] ier_wdata,
    output logic [7:0] ier_rdata,
    input  logic       master_en,
    input  logic       fifo_mode,
    input  logic       rx_avail,
    input  logic       rx_timeout,
    input  logic       line_err,
    input  logic       thr_empty,
    input  logic       thr_write,
    input  logic       iir_rd,
    input  logic       msr_rd,
    input  logic       cts,
    input  logic       dsr,
    input  logic       ri,
    input  logic       dcd,
    output logic [7:0] iir_data,
    output logic [7:0] msr_data,
    output logic       irq
);
    localparam int NLINES = 4;

    logic [IER_BITS-1:0] ier_q;
    logic [NLINES-1:0]   delta;
    logic [NLINES-1:0]   lines;
    logic                thre_pend;
    logic                pending;
    cause_e              state;

    always_ff @(posedge clk) begin
        if (!rst_n)      ier_q <= '0;
        else if (ier_wr) ier_q <= ier_wdata[IER_BITS-1:0];
    end
    assign ier_rdata = {{(8-IER_BITS){1'b0}}, ier_q};

    assign lines = {dcd, ri, dsr, cts};

    modem_delta #(.NLINES(NLINES), .TRAIL_ONLY(4'b0100)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (lines),
        .rd_clr (msr_rd),
        .delta  (delta)
    );

    thre_latch u_thre (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (thr_empty),
        .clr_wr (thr_write),
        .clr_rd (iir_rd && state == ST_THRE),
        .pend   (thre_pend)
    );

    irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_c    (ier_q[2] & line_err),
        .rx_c      (ier_q[0] & (rx_avail | (rx_timeout & fifo_mode))),
        .to_c      (rx_timeout & fifo_mode),
        .thre_c    (ier_q[1] & thre_pend),
        .mdm_c     (ier_q[3] & (|delta)),
        .fifo_mode (fifo_mode),
        .state     (state),
        .iir       (iir_data),
        .pending   (pending)
    );

    assign msr_data = {lines, delta};
    assign irq      = master_en & pending;

    // R1: write data lands in the low nibble, upper nibble stays zero
    assert_ier_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> (ier_rdata == {4'b0000, $past(ier_wdata[3:0])}));

    // R4: timeout flag only beside the receive code
    assert_timeout_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iir_data[3] |-> (iir_data[2:1] == CODE_RXD));

    // R6: master enable low holds the request line low
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> !irq);

    // R3: bit0 and the request agree when master enable is high
    assert_pending_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        master_en |-> (irq == !iir_data[0]));
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, master_en = 1, fifo_mode = 0;
    logic [7:0] ier_wdata = 8'h00;
    logic       rx_avail = 0, rx_timeout = 0, line_err = 0;
    logic       thr_empty = 0, thr_write = 0, iir_rd = 0, msr_rd = 0;
    logic       cts = 0, dsr = 0, ri = 0, dcd = 0;
    logic [7:0] ier_rdata, iir_data, msr_data;
    logic       irq;

    always #4 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .master_en(master_en), .fifo_mode(fifo_mode),
        .rx_avail(rx_avail), .rx_timeout(rx_timeout), .line_err(line_err),
        .thr_empty(thr_empty), .thr_write(thr_write), .iir_rd(iir_rd),
        .msr_rd(msr_rd), .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd),
        .iir_data(iir_data), .msr_data(msr_data), .irq(irq)
    );

    typedef enum int {S_IIR, S_IRQ, S_MSR, S_IER} sel_e;
    typedef struct {
        int    due;
        sel_e  sel;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(sel_e s);
        case (s)
            S_IIR:   return int'(iir_data);
            S_IRQ:   return int'(irq);
            S_MSR:   return int'(msr_data);
            default: return int'(ier_rdata);
        endcase
    endfunction

    // monitor: pop and compare at the due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int    got;
            it  = q.pop_front();
            got = observe(it.sel);
            checks++;
            if (it.due != cyc || got != it.exp) begin
                errors++;
                $display("FAIL %s: sel %0d cycle %0d actual 0x%0h expected 0x%0h",
                         it.tag, it.sel, cyc, got, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_in(int lat, sel_e s, int v, string tag);
        q.push_back('{due: cyc + lat, sel: s, exp: v, tag: tag});
    endtask

    task automatic drain();
        while (q.size() > 0) step();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // reset state, R3 R1 R7
        expect_in(1, S_IIR, 8'h01, "R3 reset");
        expect_in(1, S_IRQ, 0, "R3 reset irq");
        expect_in(1, S_IER, 8'h00, "R1 reset");
        expect_in(1, S_MSR, 8'h00, "R7 reset");
        drain();

        // R1: upper bits dropped
        ier_wdata = 8'hFF; ier_wr = 1;
        expect_in(1, S_IER, 8'h0F, "R1 write");
        step(); ier_wr = 0;
        drain();

        // R2 R10: line error outranks receive
        line_err = 1; rx_avail = 1;
        expect_in(1, S_IIR, 8'h06, "R2 line first");
        expect_in(1, S_IRQ, 1, "R6 irq on");
        drain();
        line_err = 0;
        expect_in(1, S_IIR, 8'h04, "R2 receive");
        drain();

        // R4 R5: timeout in FIFO mode
        rx_avail = 0; rx_timeout = 1; fifo_mode = 1;
        expect_in(1, S_IIR, 8'hCC, "R4 timeout");
        drain();
        // R4: timeout ignored without FIFO mode
        fifo_mode = 0;
        expect_in(1, S_IIR, 8'h01, "R4 no fifo");
        drain();
        rx_timeout = 0;

        // R9 R10: transmit empty via strobe, cleared by read
        thr_empty = 1;
        expect_in(2, S_IIR, 8'h02, "R9 thre set");
        step(); thr_empty = 0;
        drain();
        iir_rd = 1;
        expect_in(2, S_IIR, 8'h01, "R9 read clear");
        expect_in(2, S_IRQ, 0, "R9 irq off");
        step(); iir_rd = 0;
        drain();
        // R9: cleared by holding write
        thr_empty = 1;
        step(); thr_empty = 0;
        step();
        thr_write = 1;
        expect_in(2, S_IIR, 8'h01, "R9 write clear");
        step(); thr_write = 0;
        drain();

        // R7 R8: modem deltas
        cts = 1;
        expect_in(1, S_MSR, 8'h11, "R8 cts rise");
        expect_in(2, S_IIR, 8'h00, "R2 modem code");
        drain();
        ri = 1;
        expect_in(1, S_MSR, 8'h51, "R8 ring rise");
        drain();
        msr_rd = 1;
        expect_in(1, S_MSR, 8'h50, "R7 read clear");
        expect_in(2, S_IIR, 8'h01, "R7 cause gone");
        step(); msr_rd = 0;
        drain();
        ri = 0;
        expect_in(1, S_MSR, 8'h14, "R8 ring fall");
        expect_in(2, S_IIR, 8'h00, "R8 ring cause");
        drain();
        msr_rd = 1;
        expect_in(1, S_MSR, 8'h10, "R7 clear again");
        step(); msr_rd = 0;
        drain();

        // R6: master enable gating
        master_en = 0; line_err = 1;
        expect_in(1, S_IIR, 8'h06, "R6 pending");
        expect_in(1, S_IRQ, 0, "R6 gated");
        drain();
        master_en = 1;
        expect_in(0, S_IRQ, 1, "R6 ungated");
        drain();

        // R1 R10: disabling all enables drops the cause
        ier_wdata = 8'h00; ier_wr = 1;
        expect_in(2, S_IIR, 8'h01, "R1 disabled");
        step(); ier_wr = 0;
        drain();
        line_err = 0;

        // R7: modem flag without enable bit3 raises nothing
        dsr = 1;
        expect_in(1, S_MSR, 8'h32, "R7 dsr flag");
        expect_in(2, S_IIR, 8'h01, "R7 masked");
        drain();

        // R2: receive > transmit-empty > modem
        ier_wdata = 8'h0F; ier_wr = 1;
        step(); ier_wr = 0;
        rx_avail = 1; thr_empty = 1;
        expect_in(1, S_IIR, 8'h04, "R2 rx over thre");
        step(); thr_empty = 0;
        drain();
        rx_avail = 0;
        expect_in(1, S_IIR, 8'h02, "R2 thre over modem");
        drain();
        iir_rd = 1;
        expect_in(2, S_IIR, 8'h00, "R2 modem last");
        step(); iir_rd = 0;
        drain();

        step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule